// File: doc/BRIEF.md
# JTAG Scan-Chain Debug Bus Bridge

This block turns a 74-bit JTAG user data register into a request/acknowledge master on a parallel debug bus. A host scans a command word through the chain. When the update strobe arrives, the block starts a read or a write of one 64-bit word at an 8-bit bus address. The next scan captures the outcome: a two-bit status, the resulting data and the address of the last accepted command. If the status reports the request still outstanding, the host scans again until it reports completion. The TAP controller sits outside the block. Its capture, shift and update strobes arrive as inputs, together with a 4-bit chain select, and the block answers only when the select equals 2.

The scan side runs on TCK and the bus side runs on the system clock. A request crosses to the system clock as a toggle through a two-flop synchronizer. Completion returns the same way. The command fields and the result word are held steady while a toggle is in flight, so only the toggles need synchronizers.

The TCK side has two states. CMD_IDLE goes to CMD_WAIT on update of a read or write while the chain is selected. CMD_WAIT goes back to CMD_IDLE when the synchronized done toggle differs from the last one seen, and the result word is latched on that step. The bus side also has two states. BUS_IDLE goes to BUS_REQ when the synchronized request toggle differs from the last one seen. BUS_REQ goes back to BUS_IDLE in the system cycle in which acknowledge is sampled high; the result is latched and the done toggle flips on that step.

Top module: `jtag_dbg_bridge`

## Requirements
- R1: After JTAG reset and system reset, bus_req is low, and the first capture loads status 00, data 0 and address 0.
- R2: The scan register is 74 bits long. Bits [1:0] hold the op or status, bits [65:2] the data and bits [73:66] the address. Capture loads the response word. Each selected shift clock moves the register one place toward bit 0, with tdi entering bit 73, and tdo shows bit 0. Capture wins over shift.
- R3: An update with op 01 while idle reads the bus at the scanned address (bus_we low). Once it completes, capture returns status 00, the read data and that address.
- R4: An update with op 10 while idle writes the scanned data to the scanned address (bus_we high). Once it completes, capture returns status 00, the written data and that address.
- R5: bus_req stays high with stable address, write enable and write data until acknowledge is sampled, and falls in the next cycle. Each accepted command produces exactly one acknowledged bus transfer.
- R6: While an accepted command has not completed on the TCK side, capture loads status 11.
- R7: An update that arrives while a command is outstanding is ignored. It produces no bus transfer, and the response still reports the first command's address and data.
- R8: Op codes 00 and 11 start no bus transfer and leave the captured response unchanged.
- R9: While chain_sel is not 2, capture, shift and update have no effect. The scan register holds its value and no bus transfer starts.
- R10: The captured address field always holds the address of the last accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Scan clock |
| jtag_rst | input | 1 | Synchronous active-high reset of the TCK side |
| chain_sel | input | 4 | User chain select; the block responds at value 2 |
| cap_en | input | 1 | Capture strobe from the TAP controller |
| shift_en | input | 1 | Shift strobe from the TAP controller |
| upd_en | input | 1 | Update strobe from the TAP controller |
| tdi | input | 1 | Serial data into the scan register |
| tdo | output | 1 | Serial data out, bit 0 of the scan register |
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of the bus side |
| bus_req | output | 1 | Bus request, held until acknowledge |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 8 | Bus address |
| bus_wdata | output | 64 | Bus write data |
| bus_rdata | input | 64 | Bus read data, valid with acknowledge |
| bus_ack | input | 1 | Bus acknowledge |

## Verification
Reads and writes are swept over the all-zero and all-one addresses and over walking-one and walking-zero addresses. Each word is computed from its address, so a misplaced address or data bit shows as a wrong word. The acknowledge delay changes from transfer to transfer. A short delay checks the normal path. A delay of thousands of cycles keeps the bridge busy across several scans, which tells the polling path and the ignore-while-busy rule apart from immediate completion. A double-length shift checks the register length and bit order. No-op codes and deselected scans check that the response and the bus stay untouched.

// File: rtl/jdb_pkg.sv
`timescale 1ns/1ps
package jdb_pkg;
    localparam int OP_W = 2;

    typedef enum logic [1:0] {
        OP_NOP   = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_RSVD  = 2'b11
    } op_e;

    localparam logic [1:0] STAT_DONE = 2'b00;
    localparam logic [1:0] STAT_BUSY = 2'b11;

    typedef enum logic {
        CMD_IDLE,
        CMD_WAIT
    } cmd_state_e;

    typedef enum logic {
        BUS_IDLE,
        BUS_REQ
    } bus_state_e;
endpackage

// File: rtl/jdb_sync.sv
`timescale 1ns/1ps
module jdb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    always_ff @(posedge clk) begin
        if (rst) begin
            ff <= '0;
        end else begin
            ff <= {ff[STAGES-2:0], d};
        end
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/jdb_scan_chain.sv
`timescale 1ns/1ps
module jdb_scan_chain #(
    parameter int W = 74
) (
    input  logic         tck,
    input  logic         jrst,
    input  logic         cap_ld,
    input  logic         shift_en,
    input  logic         tdi,
    input  logic [W-1:0] cap_word,
    output logic [W-1:0] scan_q,
    output logic         tdo
);
    always_ff @(posedge tck) begin
        if (jrst) begin
            scan_q <= '0;
        end else if (cap_ld) begin
            scan_q <= cap_word;
        end else if (shift_en) begin
            scan_q <= {tdi, scan_q[W-1:1]};
        end
    end

    assign tdo = scan_q[0];
endmodule

// File: rtl/jdb_cmd_ctrl.sv
`timescale 1ns/1ps
module jdb_cmd_ctrl
    import jdb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 64
) (
    input  logic              tck,
    input  logic              jrst,
    input  logic              upd,
    input  logic [OP_W-1:0]   op,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic              done_sync,
    input  logic [DATA_W-1:0] bus_result,
    output logic              req_tgl,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              cmd_we,
    output logic              busy,
    output logic [OP_W-1:0]   status,
    output logic [DATA_W-1:0] resp_data
);
    cmd_state_e state, next_state;
    op_e        op_v;
    logic       done_seen;
    logic       accept;
    logic       finish;

    assign op_v   = op_e'(op);
    assign accept = (state == CMD_IDLE) && upd &&
                    ((op_v == OP_READ) || (op_v == OP_WRITE));
    assign finish = (state == CMD_WAIT) && (done_sync != done_seen);

    // state register
    always_ff @(posedge tck) begin
        if (jrst) begin
            state <= CMD_IDLE;
        end else begin
            state <= next_state;
        end
    end

    // next state
    always_comb begin
        next_state = state;
        unique case (state)
            CMD_IDLE: if (accept) next_state = CMD_WAIT;
            CMD_WAIT: if (finish) next_state = CMD_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy   = 1'b0;
        status = STAT_DONE;
        unique case (state)
            CMD_IDLE: begin
                busy   = 1'b0;
                status = STAT_DONE;
            end
            CMD_WAIT: begin
                busy   = 1'b1;
                status = STAT_BUSY;
            end
        endcase
    end

    // command and result registers
    always_ff @(posedge tck) begin
        if (jrst) begin
            req_tgl   <= 1'b0;
            done_seen <= 1'b0;
            cmd_addr  <= '0;
            cmd_data  <= '0;
            cmd_we    <= 1'b0;
            resp_data <= '0;
        end else begin
            if (accept) begin
                cmd_addr <= in_addr;
                cmd_data <= in_data;
                cmd_we   <= (op_v == OP_WRITE);
                req_tgl  <= ~req_tgl;
            end
            if (finish) begin
                done_seen <= done_sync;
                resp_data <= bus_result;
            end
        end
    end
endmodule

// File: rtl/jdb_bus_master.sv
`timescale 1ns/1ps
module jdb_bus_master
    import jdb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_sync,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              cmd_we,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    output logic              done_tgl,
    output logic [DATA_W-1:0] result
);
    bus_state_e state, next_state;
    logic       req_seen;
    logic       start;
    logic       complete;

    assign start    = (state == BUS_IDLE) && (req_sync != req_seen);
    assign complete = (state == BUS_REQ) && bus_ack;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= BUS_IDLE;
        end else begin
            state <= next_state;
        end
    end

    // next state
    always_comb begin
        next_state = state;
        unique case (state)
            BUS_IDLE: if (start)    next_state = BUS_REQ;
            BUS_REQ:  if (complete) next_state = BUS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_req = 1'b0;
        unique case (state)
            BUS_IDLE: bus_req = 1'b0;
            BUS_REQ:  bus_req = 1'b1;
        endcase
    end

    // transfer registers
    always_ff @(posedge clk) begin
        if (rst) begin
            req_seen  <= 1'b0;
            done_tgl  <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            result    <= '0;
        end else begin
            if (start) begin
                req_seen  <= req_sync;
                bus_we    <= cmd_we;
                bus_addr  <= cmd_addr;
                bus_wdata <= cmd_data;
            end
            if (complete) begin
                result   <= bus_we ? bus_wdata : bus_rdata;
                done_tgl <= ~done_tgl;
            end
        end
    end
endmodule

// File: rtl/jtag_dbg_bridge.sv
`timescale 1ns/1ps
module jtag_dbg_bridge
    import jdb_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 64,
    parameter int SEL_W       = 4,
    parameter int SEL_CODE    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              tck,
    input  logic              jtag_rst,
    input  logic [SEL_W-1:0]  chain_sel,
    input  logic              cap_en,
    input  logic              shift_en,
    input  logic              upd_en,
    input  logic              tdi,
    output logic              tdo,
    input  logic              clk,
    input  logic              rst,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack
);
    localparam int SCAN_W  = OP_W + DATA_W + ADDR_W;
    localparam int DATA_LO = OP_W;
    localparam int ADDR_LO = OP_W + DATA_W;

    logic              selected;
    logic [SCAN_W-1:0] scan_q;
    logic [SCAN_W-1:0] cap_word;
    logic              req_tgl, req_sync;
    logic              done_tgl, done_sync;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic              cmd_we;
    logic              cmd_busy;
    logic [OP_W-1:0]   status;
    logic [DATA_W-1:0] resp_data;
    logic [DATA_W-1:0] bus_result;

    assign selected = (chain_sel == SEL_W'(SEL_CODE));
    assign cap_word = {cmd_addr, resp_data, status};

    jdb_scan_chain #(.W(SCAN_W)) u_chain (
        .tck      (tck),
        .jrst     (jtag_rst),
        .cap_ld   (cap_en & selected),
        .shift_en (shift_en & selected),
        .tdi      (tdi),
        .cap_word (cap_word),
        .scan_q   (scan_q),
        .tdo      (tdo)
    );

    jdb_cmd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .tck        (tck),
        .jrst       (jtag_rst),
        .upd        (upd_en & selected),
        .op         (scan_q[OP_W-1:0]),
        .in_addr    (scan_q[ADDR_LO +: ADDR_W]),
        .in_data    (scan_q[DATA_LO +: DATA_W]),
        .done_sync  (done_sync),
        .bus_result (bus_result),
        .req_tgl    (req_tgl),
        .cmd_addr   (cmd_addr),
        .cmd_data   (cmd_data),
        .cmd_we     (cmd_we),
        .busy       (cmd_busy),
        .status     (status),
        .resp_data  (resp_data)
    );

    jdb_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk (clk),
        .rst (rst),
        .d   (req_tgl),
        .q   (req_sync)
    );

    jdb_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
        .clk (tck),
        .rst (jtag_rst),
        .d   (done_tgl),
        .q   (done_sync)
    );

    jdb_bus_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .clk       (clk),
        .rst       (rst),
        .req_sync  (req_sync),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .cmd_we    (cmd_we),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack),
        .done_tgl  (done_tgl),
        .result    (bus_result)
    );
endmodule

// File: rtl/jdb_bridge_checker.sv
`timescale 1ns/1ps
module jdb_bridge_checker #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 64,
    parameter int SEL_W    = 4,
    parameter int SEL_CODE = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       tck,
    input logic                       jtag_rst,
    input logic [SEL_W-1:0]           chain_sel,
    input logic                       cap_en,
    input logic                       bus_req,
    input logic                       bus_ack,
    input logic                       bus_we,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [DATA_W-1:0]          bus_wdata,
    input logic [ADDR_W+DATA_W+1:0]   scan_q,
    input logic                       cmd_busy,
    input logic [ADDR_W-1:0]          cmd_addr
);
    logic sel_ok;
    assign sel_ok = (chain_sel == SEL_W'(SEL_CODE));

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> !bus_req);  // R1

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> bus_req);  // R5

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> ($stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));  // R5

    AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_ack) |=> !bus_req);  // R5

    AST_BUSY_STATUS: assert property (@(posedge tck) disable iff (jtag_rst)
        (cap_en && sel_ok && cmd_busy) |=> (scan_q[1:0] == 2'b11));  // R6

    AST_BUSY_KEEPS_CMD: assert property (@(posedge tck) disable iff (jtag_rst)
        cmd_busy |=> $stable(cmd_addr));  // R7

    AST_DESEL_HOLD: assert property (@(posedge tck) disable iff (jtag_rst)
        !sel_ok |=> $stable(scan_q));  // R9
endmodule

bind jtag_dbg_bridge jdb_bridge_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SEL_W    (SEL_W),
    .SEL_CODE (SEL_CODE)
) u_checker (
    .clk       (clk),
    .rst       (rst),
    .tck       (tck),
    .jtag_rst  (jtag_rst),
    .chain_sel (chain_sel),
    .cap_en    (cap_en),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .scan_q    (scan_q),
    .cmd_busy  (cmd_busy),
    .cmd_addr  (cmd_addr)
);

// File: tb/test_jtag_dbg_bridge.sv
`timescale 1ns/1ps
module test_jtag_dbg_bridge;
    localparam int AW = 8;
    localparam int DW = 64;
    localparam int SW = 2 + DW + AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tck = 1'b0;
    logic          jtag_rst = 1'b1;
    logic [3:0]    chain_sel = 4'd2;
    logic          cap_en = 1'b0, shift_en = 1'b0, upd_en = 1'b0, tdi = 1'b0;
    logic          tdo;
    logic          bus_req, bus_we, bus_ack;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int ack_delay = 0;
    int wait_cnt = 0;
    int ack_total = 0;
    logic [DW-1:0] mem [0:255];

    always #2.5 clk = ~clk;

    jtag_dbg_bridge i_jtag_dbg_bridge (
        .tck(tck), .jtag_rst(jtag_rst), .chain_sel(chain_sel),
        .cap_en(cap_en), .shift_en(shift_en), .upd_en(upd_en),
        .tdi(tdi), .tdo(tdo), .clk(clk), .rst(rst),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        return (64'h9E3779B97F4A7C15 * 64'(a + 1)) ^ {32'(salt), 32'(a * 3)};
    endfunction

    // bus slave with programmable acknowledge delay
    initial bus_ack = 1'b0;
    initial bus_rdata = '0;
    always @(posedge clk) begin
        bus_ack <= 1'b0;
        if (bus_req && !bus_ack) begin
            if (wait_cnt >= ack_delay) begin
                bus_ack  <= 1'b1;
                wait_cnt <= 0;
                ack_total <= ack_total + 1;
                if (bus_we) mem[bus_addr] <= bus_wdata;
                else        bus_rdata <= mem[bus_addr];
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual=%0d cycles expected<190000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic tick();
        tck = 1'b0; #15;
        tck = 1'b1; #15;
    endtask

    task automatic chk(input string tag, input logic [SW-1:0] act, input logic [SW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one capture, 74 shifts, one update
    task automatic scan(input logic [1:0] op, input logic [DW-1:0] d,
                        input logic [AW-1:0] a, output logic [SW-1:0] resp);
        logic [SW-1:0] din;
        din = {a, d, op};
        cap_en = 1'b1; tick(); cap_en = 1'b0;
        shift_en = 1'b1;
        for (int i = 0; i < SW; i++) begin
            tdi = din[i];
            resp[i] = tdo;
            tick();
        end
        shift_en = 1'b0;
        upd_en = 1'b1; tick(); upd_en = 1'b0;
        tick();
    endtask

    task automatic poll(output logic [SW-1:0] resp, output int n);
        n = 0;
        scan(2'b00, '0, '0, resp);
        while (resp[1:0] == 2'b11 && n < 30) begin
            n++;
            scan(2'b00, '0, '0, resp);
        end
    endtask

    task automatic do_cmd(input logic [1:0] op, input logic [DW-1:0] d,
                          input logic [AW-1:0] a, output logic [SW-1:0] resp);
        logic [SW-1:0] r0;
        int n;
        scan(op, d, a, r0);
        poll(resp, n);
    endtask

    initial begin
        logic [SW-1:0] r, r2, pin, nop_word;
        logic [2*SW-1:0] longin, longout;
        logic [DW-1:0] d1, d2, keep;
        int n, acks0, ai;
        logic [AW-1:0] addrs [18];

        for (int i = 0; i < 256; i++) mem[i] = pat(i, 0);
        for (int i = 0; i < 8; i++) begin
            addrs[i]     = 8'(1 << i);
            addrs[8 + i] = ~8'(1 << i);
        end
        addrs[16] = 8'h00;
        addrs[17] = 8'hFF;

        for (int i = 0; i < 5; i++) tick();
        jtag_rst = 1'b0;
        rst = 1'b0;
        tick();

        // R1: reset response and idle bus
        tests++;
        if (bus_req !== 1'b0) begin
            fails++;
            $display("FAIL R1 bus_req actual=%b expected=0", bus_req);
        end
        scan(2'b00, '0, '0, r);
        chk("R1 reset response", r, '0);

        // R2: length and order of the scan register, by a double-length shift
        pin = {8'hA5, 64'h0123456789ABCDEF, 2'b11};
        nop_word = {8'h3C, 64'hFEDCBA9876543210, 2'b00};
        longin = {nop_word, pin};
        cap_en = 1'b1; tick(); cap_en = 1'b0;
        shift_en = 1'b1;
        for (int i = 0; i < 2 * SW; i++) begin
            tdi = longin[i];
            longout[i] = tdo;
            tick();
        end
        shift_en = 1'b0;
        upd_en = 1'b1; tick(); upd_en = 1'b0; tick();
        chk("R2 captured half", longout[SW-1:0], '0);
        chk("R2 delayed half", longout[2*SW-1:SW], pin);

        // R3 R4 R10: sweep over walking addresses with varied ack delay
        for (int k = 0; k < 18; k++) begin
            ai = int'(addrs[k]);
            ack_delay = (k * 7) % 13;
            acks0 = ack_total;
            do_cmd(2'b01, pat(k, 5), addrs[k], r);
            chk("R3 read before write", r, {addrs[k], pat(ai, 0), 2'b00});
            d1 = pat(ai, k + 11);
            do_cmd(2'b10, d1, addrs[k], r);
            chk("R4 write response", r, {addrs[k], d1, 2'b00});
            chk("R4 slave memory", SW'(mem[ai]), SW'(d1));
            do_cmd(2'b01, '0, addrs[k], r);
            chk("R10 read back", r, {addrs[k], d1, 2'b00});
            chk("R5 one transfer per command", SW'(ack_total - acks0), SW'(3));
        end

        // R6 R7: long acknowledge delay, second command while busy
        ack_delay = 2000;
        acks0 = ack_total;
        d1 = 64'h1111_2222_3333_4444;
        d2 = 64'h5555_6666_7777_8888;
        keep = mem[8'h20];
        scan(2'b10, d1, 8'h10, r);
        scan(2'b10, d2, 8'h20, r2);
        chk("R6 busy status", SW'(r2[1:0]), SW'(2'b11));
        poll(r, n);
        tests++;
        if (n < 1) begin
            fails++;
            $display("FAIL R6 busy polls actual=%0d expected>=1", n);
        end
        chk("R7 first command kept", r, {8'h10, d1, 2'b00});
        chk("R7 single transfer", SW'(ack_total - acks0), SW'(1));
        chk("R7 ignored address untouched", SW'(mem[8'h20]), SW'(keep));

        // R8: no-op codes 00 and 11
        ack_delay = 0;
        acks0 = ack_total;
        scan(2'b00, 64'hDEAD, 8'h77, r2);
        scan(2'b11, 64'hBEEF, 8'h66, r2);
        scan(2'b00, '0, '0, r2);
        chk("R8 response unchanged", r2, {8'h10, d1, 2'b00});
        chk("R8 no transfer", SW'(ack_total - acks0), SW'(0));

        // R9: deselected chain ignores capture, shift and update
        chain_sel = 4'd0;
        scan(2'b01, 64'h0, 8'h33, r2);
        for (int i = 0; i < 20; i++) tick();
        chk("R9 no transfer", SW'(ack_total - acks0), SW'(0));
        chain_sel = 4'd2;
        tick();
        scan(2'b00, '0, '0, r2);
        chk("R9 response unchanged", r2, {8'h10, d1, 2'b00});

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule